// File: doc/BRIEF.md
# SPI Controller Status Flags

This block keeps the status flags of an SPI controller and presents them as one read-only status word. It takes hardware events from the shift serializer (a received word moved into the receive holding register, a transmit word handed over for shifting), from the mode-fault detector and from a simple transfer-counter DMA channel (counter reached zero, plus the live values of the current and next receive counters). It also watches the register bus, so that the right read or write access clears each flag.

Every flag is a register that updates on the rising clock edge after its event or clearing access. A flag's set event always wins over a clearing access in the same cycle, so no event is lost. The status word shows the flag values before a read-clear takes effect. The read that clears the flags therefore returns the values that caused the clear.

Top module: `spi_stat_flags`

## Requirements
- R1: While `rst` is high, and on the first edge after it, every bit of `status_word` is 0. The enable state is off after reset.
- R2: Receive-full (bit 1) goes to 1 on the edge after `ser_rx_load`. It goes to 0 on the edge after a read of the receive data address (`bus_rd` with `bus_addr == 2`), unless `ser_rx_load` is also high in that cycle.
- R3: Overrun (bit 5) goes to 1 on the edge after `ser_rx_load` when receive-full is already 1 and the receive data address is not read in that cycle. It stays 1 until a read of the status address (`bus_addr == 4`); if a new overrun event comes in the same cycle, it stays 1.
- R4: Mode fault (bit 6) goes to 1 on the edge after `mode_fault_evt`. Only a status address read clears it, and a fault in the same cycle as that read keeps it at 1.
- R5: Transmit-empty (bit 0) is 0 after reset. `en_cmd` sets it to 1 and turns the enable state on. `dis_cmd` clears it and turns the enable state off, and wins over `en_cmd`. While disabled, `ser_tx_take` has no effect.
- R6: While enabled, a write to the transmit data address (`bus_wr`, `bus_addr == 3`) clears transmit-empty and `ser_tx_take` sets it. When both come in the same cycle, the result is 1.
- R7: End-of-receive (bit 3) is set by `rx_cnt_done` and cleared by a write to address 8. End-of-transmit (bit 2) is set by `tx_cnt_done` and cleared by a write to address 9. For both, the set wins.
- R8: Receive-buffer-full (bit 4) equals, one edge later, whether `rx_cur_cnt` and `rx_nxt_cnt` are both zero.
- R9: A write to the status address changes no flag. Reads of any address other than the status address leave overrun and mode fault unchanged. A disable command leaves overrun and mode fault unchanged.
- R10: Bits 31 down to 7 of `status_word` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_cmd | input | 1 | Controller enable command pulse |
| dis_cmd | input | 1 | Controller disable command pulse |
| ser_rx_load | input | 1 | Serializer moved a received word into the receive holding register |
| ser_tx_take | input | 1 | Serializer took the word from the transmit holding register |
| mode_fault_evt | input | 1 | Mode fault detected |
| rx_cnt_done | input | 1 | Receive transfer counter reached zero |
| tx_cnt_done | input | 1 | Transmit transfer counter reached zero |
| rx_cur_cnt | input | CNT_W | Current receive transfer counter value |
| rx_nxt_cnt | input | CNT_W | Next receive transfer counter value |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| status_word | output | STAT_W | Status word, read-only |

## Verification
Each flag is its own register and feeds the status word with no logic in between. A wrong set or clear decision therefore shows up as a wrong bit on the very next edge. A flag that was wrongly set or cleared stays wrong until its next legitimate event. The sticky error bits and the two end flags can hold such an error for many cycles, so the bench compares every bit of the word on every cycle against a reference model. The model is driven by random events and bus accesses, with directed same-cycle set/clear collisions mixed in.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  // Bit positions within the status word
  localparam int unsigned BIT_TXE  = 0;
  localparam int unsigned BIT_RXF  = 1;
  localparam int unsigned BIT_ETX  = 2;
  localparam int unsigned BIT_ERX  = 3;
  localparam int unsigned BIT_RXB  = 4;
  localparam int unsigned BIT_OVR  = 5;
  localparam int unsigned BIT_MODF = 6;
  localparam int unsigned USED_W   = 7;

  // Indices of the generic sticky flags
  localparam int unsigned STK_MODF = 0;
  localparam int unsigned STK_ERX  = 1;
  localparam int unsigned STK_ETX  = 2;
  localparam int unsigned STK_N    = 3;
endpackage

// File: rtl/stat_sticky.sv
module stat_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/stat_rx_path.sv
module stat_rx_path (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic data_rd_i,
  input  logic stat_rd_i,
  output logic full_o,
  output logic ovr_o
);
  logic ovr_evt;

  // A second load with no data read in the same cycle loses a word
  assign ovr_evt = load_i && full_o && !data_rd_i;

  always_ff @(posedge clk) begin
    if (rst)            full_o <= 1'b0;
    else if (load_i)    full_o <= 1'b1;
    else if (data_rd_i) full_o <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)            ovr_o <= 1'b0;
    else if (ovr_evt)   ovr_o <= 1'b1;
    else if (stat_rd_i) ovr_o <= 1'b0;
  end
endmodule

// File: rtl/stat_tx_path.sv
module stat_tx_path (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic dis_i,
  input  logic take_i,
  input  logic data_wr_i,
  output logic empty_o
);
  logic enabled_q;

  always_ff @(posedge clk) begin
    if (rst)        enabled_q <= 1'b0;
    else if (dis_i) enabled_q <= 1'b0;
    else if (en_i)  enabled_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                       empty_o <= 1'b0;
    else if (dis_i)                empty_o <= 1'b0;
    else if (en_i)                 empty_o <= 1'b1;
    else if (enabled_q && take_i)  empty_o <= 1'b1;
    else if (data_wr_i)            empty_o <= 1'b0;
  end
endmodule

// File: rtl/stat_buf_full.sv
module stat_buf_full #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cur_i,
  input  logic [CNT_W-1:0] nxt_i,
  output logic             full_o
);
  always_ff @(posedge clk) begin
    if (rst) full_o <= 1'b0;
    else     full_o <= (cur_i == '0) && (nxt_i == '0);
  end
endmodule

// File: rtl/spi_stat_flags.sv
module spi_stat_flags
  import spi_stat_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned STAT_W = 32,
  parameter logic [ADDR_W-1:0] A_RXD  = 2,
  parameter logic [ADDR_W-1:0] A_TXD  = 3,
  parameter logic [ADDR_W-1:0] A_STAT = 4,
  parameter logic [ADDR_W-1:0] A_RCNT = 8,
  parameter logic [ADDR_W-1:0] A_TCNT = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_cmd,
  input  logic              dis_cmd,
  input  logic              ser_rx_load,
  input  logic              ser_tx_take,
  input  logic              mode_fault_evt,
  input  logic              rx_cnt_done,
  input  logic              tx_cnt_done,
  input  logic [CNT_W-1:0]  rx_cur_cnt,
  input  logic [CNT_W-1:0]  rx_nxt_cnt,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [STAT_W-1:0] status_word
);
  localparam int unsigned PAD_W = STAT_W - USED_W;

  // Access decode
  logic rd_stat, rd_rxd, wr_txd, wr_rcnt, wr_tcnt;
  assign rd_stat = bus_rd && (bus_addr == A_STAT);
  assign rd_rxd  = bus_rd && (bus_addr == A_RXD);
  assign wr_txd  = bus_wr && (bus_addr == A_TXD);
  assign wr_rcnt = bus_wr && (bus_addr == A_RCNT);
  assign wr_tcnt = bus_wr && (bus_addr == A_TCNT);

  logic rxf, ovr, txe, rxb;
  logic [STK_N-1:0] stk_set, stk_clr, stk_q;

  assign stk_set[STK_MODF] = mode_fault_evt;
  assign stk_clr[STK_MODF] = rd_stat;
  assign stk_set[STK_ERX]  = rx_cnt_done;
  assign stk_clr[STK_ERX]  = wr_rcnt;
  assign stk_set[STK_ETX]  = tx_cnt_done;
  assign stk_clr[STK_ETX]  = wr_tcnt;

  for (genvar g = 0; g < STK_N; g++) begin : g_stk
    stat_sticky u_flag (
      .clk    (clk),
      .rst    (rst),
      .set_i  (stk_set[g]),
      .clr_i  (stk_clr[g]),
      .flag_o (stk_q[g])
    );
  end

  stat_rx_path u_rx (
    .clk       (clk),
    .rst       (rst),
    .load_i    (ser_rx_load),
    .data_rd_i (rd_rxd),
    .stat_rd_i (rd_stat),
    .full_o    (rxf),
    .ovr_o     (ovr)
  );

  stat_tx_path u_tx (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en_cmd),
    .dis_i     (dis_cmd),
    .take_i    (ser_tx_take),
    .data_wr_i (wr_txd),
    .empty_o   (txe)
  );

  stat_buf_full #(.CNT_W(CNT_W)) u_buf (
    .clk    (clk),
    .rst    (rst),
    .cur_i  (rx_cur_cnt),
    .nxt_i  (rx_nxt_cnt),
    .full_o (rxb)
  );

  logic [USED_W-1:0] used_bits;
  always_comb begin
    used_bits           = '0;
    used_bits[BIT_TXE]  = txe;
    used_bits[BIT_RXF]  = rxf;
    used_bits[BIT_ETX]  = stk_q[STK_ETX];
    used_bits[BIT_ERX]  = stk_q[STK_ERX];
    used_bits[BIT_RXB]  = rxb;
    used_bits[BIT_OVR]  = ovr;
    used_bits[BIT_MODF] = stk_q[STK_MODF];
  end

  assign status_word = {{PAD_W{1'b0}}, used_bits};
endmodule

// File: rtl/spi_stat_flags_chk.sv
module spi_stat_flags_chk
  import spi_stat_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned STAT_W = 32,
  parameter logic [ADDR_W-1:0] A_RXD  = 2,
  parameter logic [ADDR_W-1:0] A_STAT = 4,
  parameter logic [ADDR_W-1:0] A_RCNT = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              dis_cmd,
  input logic              ser_rx_load,
  input logic              mode_fault_evt,
  input logic              rx_cnt_done,
  input logic [CNT_W-1:0]  rx_cur_cnt,
  input logic [CNT_W-1:0]  rx_nxt_cnt,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [STAT_W-1:0] status_word
);
  logic rd_rxd, rd_stat;
  assign rd_rxd  = bus_rd && (bus_addr == A_RXD);
  assign rd_stat = bus_rd && (bus_addr == A_STAT);

  // R2
  rxfull_set_chk: assert property (@(posedge clk) disable iff (rst)
    ser_rx_load |=> status_word[BIT_RXF]);

  // R3
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_rx_load && status_word[BIT_RXF] && !rd_rxd) |=> status_word[BIT_OVR]);

  // R4
  modf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (status_word[BIT_MODF] && !rd_stat) |=> status_word[BIT_MODF]);

  // R4
  modf_set_chk: assert property (@(posedge clk) disable iff (rst)
    mode_fault_evt |=> status_word[BIT_MODF]);

  // R5
  txe_disable_chk: assert property (@(posedge clk) disable iff (rst)
    dis_cmd |=> !status_word[BIT_TXE]);

  // R7
  endrx_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt_done || (status_word[BIT_ERX] && !(bus_wr && bus_addr == A_RCNT)))
      |=> status_word[BIT_ERX]);

  // R8
  rxbuf_full_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_word[BIT_RXB] ==
              $past((rx_cur_cnt == '0) && (rx_nxt_cnt == '0))));

  // R10
  unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    status_word[STAT_W-1:USED_W] == '0);
endmodule

bind spi_stat_flags spi_stat_flags_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .STAT_W(STAT_W),
  .A_RXD(A_RXD), .A_STAT(A_STAT), .A_RCNT(A_RCNT)
) chk_i (
  .clk(clk), .rst(rst), .dis_cmd(dis_cmd), .ser_rx_load(ser_rx_load),
  .mode_fault_evt(mode_fault_evt), .rx_cnt_done(rx_cnt_done),
  .rx_cur_cnt(rx_cur_cnt), .rx_nxt_cnt(rx_nxt_cnt), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .status_word(status_word)
);

// File: tb/spi_stat_flags_tb.sv
module spi_stat_flags_tb_top;
  localparam int CNT_W = 4;
  localparam int ADDR_W = 4;
  localparam int STAT_W = 32;
  localparam logic [3:0] A_RXD = 2, A_TXD = 3, A_STAT = 4, A_RCNT = 8, A_TCNT = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_cmd = 0, dis_cmd = 0, ser_rx_load = 0, ser_tx_take = 0;
  logic mode_fault_evt = 0, rx_cnt_done = 0, tx_cnt_done = 0;
  logic [CNT_W-1:0] rx_cur_cnt = '0, rx_nxt_cnt = '0;
  logic bus_rd = 0, bus_wr = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [STAT_W-1:0] status_word;

  always #5 clk = ~clk;

  spi_stat_flags #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .STAT_W(STAT_W)) dut_i (
    .clk(clk), .rst(rst), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
    .ser_rx_load(ser_rx_load), .ser_tx_take(ser_tx_take),
    .mode_fault_evt(mode_fault_evt), .rx_cnt_done(rx_cnt_done),
    .tx_cnt_done(tx_cnt_done), .rx_cur_cnt(rx_cur_cnt), .rx_nxt_cnt(rx_nxt_cnt),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .status_word(status_word)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Reference model state
  logic m_en = 0, m_txe = 0, m_rxf = 0, m_etx = 0, m_erx = 0;
  logic m_rxb = 0, m_ovr = 0, m_modf = 0;

  function automatic logic [STAT_W-1:0] exp_word();
    logic [STAT_W-1:0] w = '0;
    w[0] = m_txe; w[1] = m_rxf; w[2] = m_etx; w[3] = m_erx;
    w[4] = m_rxb; w[5] = m_ovr; w[6] = m_modf;
    return w;
  endfunction

  function automatic string bit_req(int b);
    case (b)
      0: return "R5/R6 txempty";
      1: return "R2 rxfull";
      2: return "R7 endtx";
      3: return "R7 endrx";
      4: return "R8 rxbuff";
      5: return "R3/R9 overrun";
      6: return "R4/R9 modefault";
      default: return "R10 unused";
    endcase
  endfunction

  task automatic compare_word(string ctx);
    logic [STAT_W-1:0] e = exp_word();
    for (int b = 0; b < STAT_W; b++) begin
      n_chk++;
      if (status_word[b] !== e[b]) begin
        n_fail++;
        $display("FAIL %s bit %0d (%s): actual %0b expected %0b", ctx, b, bit_req(b),
                 status_word[b], e[b]);
      end
    end
  endtask

  // Drive one cycle of inputs and advance the model across the next edge
  task automatic apply(logic en, logic dis, logic rl, logic tt, logic mf,
                       logic rcd, logic tcd, logic [CNT_W-1:0] rc, logic [CNT_W-1:0] rn,
                       logic brd, logic bwr, logic [ADDR_W-1:0] ad);
    logic rs, rr, wt, wrc, wtc, n_ovr;
    en_cmd = en; dis_cmd = dis; ser_rx_load = rl; ser_tx_take = tt;
    mode_fault_evt = mf; rx_cnt_done = rcd; tx_cnt_done = tcd;
    rx_cur_cnt = rc; rx_nxt_cnt = rn; bus_rd = brd; bus_wr = bwr; bus_addr = ad;
    rs  = brd && ad == A_STAT;
    rr  = brd && ad == A_RXD;
    wt  = bwr && ad == A_TXD;
    wrc = bwr && ad == A_RCNT;
    wtc = bwr && ad == A_TCNT;
    n_ovr = (rl && m_rxf && !rr) ? 1'b1 : rs ? 1'b0 : m_ovr;
    m_rxf  = rl ? 1'b1 : rr ? 1'b0 : m_rxf;
    m_ovr  = n_ovr;
    m_modf = mf ? 1'b1 : rs ? 1'b0 : m_modf;
    m_erx  = rcd ? 1'b1 : wrc ? 1'b0 : m_erx;
    m_etx  = tcd ? 1'b1 : wtc ? 1'b0 : m_etx;
    m_rxb  = (rc == 0) && (rn == 0);
    m_txe  = dis ? 1'b0 : en ? 1'b1 : (m_en && tt) ? 1'b1 : wt ? 1'b0 : m_txe;
    m_en   = dis ? 1'b0 : en ? 1'b1 : m_en;
  endtask

  task automatic step(string ctx, logic en, logic dis, logic rl, logic tt, logic mf,
                      logic rcd, logic tcd, logic [CNT_W-1:0] rc, logic [CNT_W-1:0] rn,
                      logic brd, logic bwr, logic [ADDR_W-1:0] ad);
    @(negedge clk);
    compare_word(ctx);
    apply(en, dis, rl, tt, mf, rcd, tcd, rc, rn, brd, bwr, ad);
  endtask

  initial begin
    int unsigned wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_word("R1 during reset");
    rst = 1'b0;
    apply(0,0,0,0,0,0,0, 4'd1, 4'd0, 0,0, '0);
    // R1: first edge after reset, all zero (counters nonzero keeps rxbuff 0)
    step("R1 after reset", 0,0,0,0,0,0,0, 4'd1,4'd0, 0,0,'0);
    // R5: take while disabled ignored, then enable
    step("R5 take disabled", 0,0,0,1,0,0,0, 4'd1,4'd0, 0,0,'0);
    step("R5 enable",        1,0,0,0,0,0,0, 4'd1,4'd0, 0,0,'0);
    // R6: write tx data, then write and take together
    step("R6 write txd",     0,0,0,0,0,0,0, 4'd1,4'd0, 0,1,A_TXD);
    step("R6 set wins",      0,0,0,1,0,0,0, 4'd1,4'd0, 0,1,A_TXD);
    // R2/R3: two loads -> overrun
    step("R2 load1",         0,0,1,0,0,0,0, 4'd1,4'd0, 0,0,'0);
    step("R3 load2",         0,0,1,0,0,0,0, 4'd1,4'd0, 0,0,'0);
    // R3: load together with data read: no new overrun trigger
    step("R3 stat read",     0,0,0,0,0,0,0, 4'd1,4'd0, 1,0,A_STAT);
    step("R3 load+read",     0,0,1,0,0,0,0, 4'd1,4'd0, 1,0,A_RXD);
    // R4: fault with same-cycle status read stays set
    step("R4 fault+read",    0,0,0,0,1,0,0, 4'd1,4'd0, 1,0,A_STAT);
    // R9: write status address, read other address, disable
    step("R9 wr status",     0,0,0,0,0,0,0, 4'd1,4'd0, 0,1,A_STAT);
    step("R9 rd other",      0,0,0,0,0,0,0, 4'd1,4'd0, 1,0,A_TCNT);
    step("R9 disable",       0,1,0,0,0,0,0, 4'd1,4'd0, 0,0,'0);
    // R5: enable and disable together -> disable wins
    step("R5 en+dis",        1,1,0,0,0,0,0, 4'd0,4'd0, 0,0,'0);
    // R7: done with same-cycle counter write
    step("R7 done+wr",       0,0,0,0,0,1,1, 4'd0,4'd0, 0,1,A_RCNT);
    step("R7 wr tcnt",       0,0,0,0,0,0,0, 4'd0,4'd3, 0,1,A_TCNT);
    step("R7 wr rcnt",       0,0,0,0,0,0,0, 4'd0,4'd0, 0,1,A_RCNT);
    step("R8 check",         0,0,0,0,0,0,0, 4'd0,4'd0, 0,0,'0);
    // Constrained random phase
    for (int i = 0; i < 3000; i++) begin
      logic [ADDR_W-1:0] ad;
      int unsigned sel = $urandom % 6;
      logic brd, bwr;
      case (sel)
        0: ad = A_RXD; 1: ad = A_TXD; 2: ad = A_STAT;
        3: ad = A_RCNT; 4: ad = A_TCNT; default: ad = 4'd7;
      endcase
      brd = ($urandom % 10) < 3;
      bwr = !brd && (($urandom % 10) < 3);
      step("random R1-mix",
           ($urandom % 50) == 0, ($urandom % 80) == 0,
           ($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 30) == 0,
           ($urandom % 20) == 0, ($urandom % 20) == 0,
           (($urandom % 3) == 0) ? 4'd0 : 4'($urandom),
           (($urandom % 2) == 0) ? 4'd0 : 4'($urandom),
           brd, bwr, ad);
    end
    @(negedge clk);
    compare_word("final");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule